// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steps through a microprogram that sits in a small writable RAM. Each stored word carries two things. The first is a set of encoded control subfields that drive an external datapath. The second is sequencing information that picks the next word to run. An address register selects the word that runs in the current cycle. The word is read at once. Each subfield is decoded into its own group of one-hot control lines. In the same cycle the next address is worked out, so the following word is ready at the next clock edge.

Sequencing is implicit. The address steps by one unless the word is a branch and its selected status condition is true. In that case the branch target is loaded instead. A plain write port lets the microprogram be replaced while the system runs. While that port is in use, sequencing stops and every control line is held low. The write port has no handshake. A write is accepted on every cycle in which the enable is high, so the port never applies back-pressure.

Top module: `useq_core`

## Requirements
- R1: A stored word is 19 bits. Bit 18 is the branch flag. Bits 17:15 are the condition select. Bits 14:9 are the branch target. The three 3-bit control codes sit in bits 8:6 (group 2), 5:3 (group 1) and 2:0 (group 0).
- R2: A synchronous reset puts the microprogram address at 0.
- R3: A word with the branch flag clear moves the address to the current address plus one.
- R4: A branch word whose selected condition is false also moves the address to the current address plus one.
- R5: A branch word whose selected condition is true loads the branch target. Select value 0 is always true. Select value k (1 to 7) tests `status_i[k-1]`.
- R6: Stepping past address 63 wraps to address 0.
- R7: A control code c from 1 to 7 in group g drives `ctrl_o[g*7 + c - 1]` high. Code 0 drives every line of its group low. The groups decode independently.
- R8: Within any group, at most one control line is high in any cycle.
- R9: While `ld_en` is high, the address holds and all of `ctrl_o` is low. `ld_word` is stored at `ld_addr` on that clock edge.
- R10: Rewriting a word at run time changes what that address produces the next time it is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Store write enable; halts sequencing |
| ld_addr | input | 6 | Store word address to write |
| ld_word | input | 19 | Microinstruction to write |
| status_i | input | 7 | Status conditions from the datapath |
| upc_o | output | 6 | Current microprogram address |
| ctrl_o | output | 21 | Decoded control lines, 7 per group |

## Verification
The properties assume that every store word the sequencer reaches has been written since power-up. RAM contents are otherwise undefined, so the decoded lines would be meaningless. The stimulus therefore fills all 64 words while the write enable is high, before it first lets the sequencer run. The properties also assume that the status vector and the write controls change only between clock edges. The stimulus drives them on the falling edge and samples results just after. Branch outcomes are tested with status patterns that set every bit except the selected one, and then only the selected one. A wrong select index therefore changes the observed address.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // How the next microprogram address is formed
  typedef enum logic [1:0] {
    NA_STEP = 2'd0,
    NA_JUMP = 2'd1,
    NA_HOLD = 2'd2
  } na_kind_e;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 19
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hold,
  input  logic                  is_branch,
  input  logic [SEL_W-1:0]      sel,
  input  logic [ADDR_W-1:0]     target,
  input  logic [2**SEL_W-2:0]   status,
  output logic [ADDR_W-1:0]     pc_o
);
  localparam int NCOND = 2 ** SEL_W;

  logic [NCOND-1:0]  cond_vec;
  logic              cond_true;
  na_kind_e          kind;
  logic [ADDR_W-1:0] pc_q;

  // entry 0 is the always-true condition
  assign cond_vec  = {status, 1'b1};
  assign cond_true = cond_vec[sel];

  always_comb begin
    if (hold)                         kind = NA_HOLD;
    else if (is_branch && cond_true)  kind = NA_JUMP;
    else                              kind = NA_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else begin
      unique case (kind)
        NA_HOLD: pc_q <= pc_q;
        NA_JUMP: pc_q <= target;
        default: pc_q <= pc_q + 1'b1;
      endcase
    end
  end

  assign pc_o = pc_q;

  AST_RESET_HOME: assert property (@(posedge clk) rst |=> pc_q == '0); // R2
  AST_STEP_ON: assert property (@(posedge clk) disable iff (rst)
    (!hold && !is_branch) |=> pc_q == $past(pc_q) + 1'b1); // R3
  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (!hold && is_branch && !cond_vec[sel]) |=> pc_q == $past(pc_q) + 1'b1); // R4
  AST_TAKE_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!hold && is_branch && cond_vec[sel]) |=> pc_q == $past(target)); // R5
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!hold && !is_branch && pc_q == '1) |=> pc_q == '0); // R6
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(pc_q)); // R9
endmodule

// File: rtl/useq_field_dec.sv
module useq_field_dec #(
  parameter int CODE_W = 3
) (
  input  logic                 en,
  input  logic [CODE_W-1:0]    code,
  output logic [2**CODE_W-2:0] lines
);
  localparam int NLINES = 2 ** CODE_W - 1;

  always_comb begin
    for (int i = 0; i < NLINES; i++) begin
      lines[i] = en && (code == CODE_W'(i + 1));
    end
  end

  always_comb begin
    AST_GROUP_EXCL: assert ($onehot0(lines)); // R8
    if (en && code != '0) begin
      AST_CODE_FIRES: assert ($countones(lines) == 1); // R7
    end else begin
      AST_CODE_IDLE: assert (lines == '0); // R7
    end
  end
endmodule

// File: rtl/useq_core.sv
module useq_core #(
  parameter int ADDR_W = 6,
  parameter int SEL_W  = 3,
  parameter int CODE_W = 3,
  parameter int N_SUB  = 3,
  localparam int NLINES = 2 ** CODE_W - 1,
  localparam int STAT_W = 2 ** SEL_W - 1,
  localparam int CTRL_W = N_SUB * NLINES,
  localparam int WORD_W = 1 + SEL_W + ADDR_W + N_SUB * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_word,
  input  logic [STAT_W-1:0] status_i,
  output logic [ADDR_W-1:0] upc_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  // word layout, low to high: codes, target, select, branch flag
  localparam int TGT_LO = N_SUB * CODE_W;
  localparam int SEL_LO = TGT_LO + ADDR_W;
  localparam int BR_BIT = SEL_LO + SEL_W;

  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] word;

  useq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
    .clk   (clk),
    .we    (ld_en),
    .waddr (ld_addr),
    .wdata (ld_word),
    .raddr (pc),
    .rdata (word)
  );

  useq_next #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_next (
    .clk       (clk),
    .rst       (rst),
    .hold      (ld_en),
    .is_branch (word[BR_BIT]),
    .sel       (word[SEL_LO +: SEL_W]),
    .target    (word[TGT_LO +: ADDR_W]),
    .status    (status_i),
    .pc_o      (pc)
  );

  for (genvar g = 0; g < N_SUB; g++) begin : g_dec
    useq_field_dec #(.CODE_W(CODE_W)) u_dec (
      .en    (!ld_en),
      .code  (word[g*CODE_W +: CODE_W]),
      .lines (ctrl_o[g*NLINES +: NLINES])
    );
  end

  assign upc_o = pc;

  AST_QUIET_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> ctrl_o == '0); // R9
endmodule

// File: tb/useq_core_test.sv
module useq_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en;
  logic [5:0]  ld_addr;
  logic [18:0] ld_word;
  logic [6:0]  status_i;
  logic [5:0]  upc_o;
  logic [20:0] ctrl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  useq_core uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_word(ld_word), .status_i(status_i), .upc_o(upc_o), .ctrl_o(ctrl_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // status presented while each row's word executes
  localparam logic [6:0] ROW_ST [NROWS] = '{
    7'b0000000, 7'b1111101, 7'b1000000, 7'b0000000, 7'b0000000,
    7'b0000000, 7'b0000000, 7'b0000000, 7'b0000010, 7'b0000000};
  // expected address of each row
  localparam int ROW_PC [NROWS] = '{0, 1, 2, 10, 11, 62, 63, 0, 1, 10};
  // expected codes {g2,g1,g0} of each row
  localparam logic [8:0] ROW_CODE [NROWS] = '{
    9'o007, 9'o100, 9'o050, 9'o777, 9'o234,
    9'o000, 9'o301, 9'o007, 9'o100, 9'o777};

  // R1 layout: {branch, select[2:0], target[5:0], g2, g1, g0}
  function automatic logic [18:0] mk(input logic br, input logic [2:0] sel,
                                     input logic [5:0] tgt, input logic [8:0] codes);
    return {br, sel, tgt, codes};
  endfunction

  // R7 line mapping: code c in group g drives line g*7 + c - 1
  function automatic logic [20:0] lines_of(input logic [8:0] codes);
    logic [20:0] r = '0;
    for (int g = 0; g < 3; g++) begin
      int c = int'(codes[g*3 +: 3]);
      if (c != 0) r[g*7 + c - 1] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [18:0] prog(input int a);
    case (a)
      0:  return mk(1'b0, 3'd0, 6'd0,  9'o007);
      1:  return mk(1'b1, 3'd2, 6'd10, 9'o100); // tests status[1]
      2:  return mk(1'b1, 3'd7, 6'd10, 9'o050); // tests status[6]
      10: return mk(1'b0, 3'd0, 6'd0,  9'o777);
      11: return mk(1'b1, 3'd0, 6'd62, 9'o234); // unconditional
      62: return mk(1'b0, 3'd0, 6'd0,  9'o000);
      63: return mk(1'b0, 3'd0, 6'd0,  9'o301);
      default: return mk(1'b0, 3'd0, 6'd0, 9'o000);
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    report();
  end

  initial begin
    rst = 1'b1; ld_en = 1'b0; ld_addr = '0; ld_word = '0; status_i = '0;
    repeat (2) @(negedge clk);
    chk(upc_o == 6'd0, "R2 reset address", 32'(upc_o), 0);

    // fill the store while halted
    rst = 1'b0;
    ld_en = 1'b1;
    for (int a = 0; a < 64; a++) begin
      ld_addr = 6'(a);
      ld_word = prog(a);
      #1;
      if (a == 5) begin
        chk(ctrl_o == '0, "R9 lines low during load", 32'(ctrl_o), 0);
        chk(upc_o == 6'd0, "R9 address held during load", 32'(upc_o), 0);
      end
      @(negedge clk);
    end
    ld_en = 1'b0;

    // table walk: R3 step, R4 fall-through, R5 taken, R6 wrap, R7 R8 decode
    for (int i = 0; i < NROWS; i++) begin
      status_i = ROW_ST[i];
      #1;
      chk(upc_o == 6'(ROW_PC[i]), "R3 R4 R5 R6 address", 32'(upc_o), 32'(ROW_PC[i]));
      chk(ctrl_o == lines_of(ROW_CODE[i]), "R7 R8 decoded lines",
          32'(ctrl_o), 32'(lines_of(ROW_CODE[i])));
      @(negedge clk);
    end
    status_i = '0;

    // R9 and R10: rewrite word 11 and word 40 while halted at 11
    ld_en = 1'b1;
    ld_addr = 6'd11;
    ld_word = mk(1'b1, 3'd0, 6'd40, 9'o006);
    #1;
    chk(upc_o == 6'd11, "R9 halted address", 32'(upc_o), 11);
    chk(ctrl_o == '0, "R9 lines forced low", 32'(ctrl_o), 0);
    @(negedge clk);
    ld_addr = 6'd40;
    ld_word = mk(1'b0, 3'd0, 6'd0, 9'o400);
    #1;
    chk(upc_o == 6'd11, "R9 address still held", 32'(upc_o), 11);
    @(negedge clk);
    ld_en = 1'b0;
    #1;
    chk(ctrl_o == lines_of(9'o006), "R10 rewritten word decodes",
        32'(ctrl_o), 32'(lines_of(9'o006)));
    @(negedge clk);
    chk(upc_o == 6'd40, "R10 R5 rewritten jump taken", 32'(upc_o), 40);
    chk(ctrl_o == lines_of(9'o400), "R10 R7 new word at target",
        32'(ctrl_o), 32'(lines_of(9'o400)));
    @(negedge clk);
    chk(upc_o == 6'd41, "R3 step after target", 32'(upc_o), 41);

    // reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(upc_o == 6'd0, "R2 mid-run reset", 32'(upc_o), 0);
    #1;
    chk(ctrl_o == lines_of(9'o007), "R1 word 0 fields after reset",
        32'(ctrl_o), 32'(lines_of(9'o007)));
    @(negedge clk);
    report();
  end
endmodule